// File: doc/BRIEF.md
# Layered Pixel Priority Mixer

The mixer takes one background pixel and one sprite pixel for each dot clock of active display. It merges them into a single 9-bit palette index for the palette stage that follows. The background pixel comes with a 4-bit sub-palette. The sprite pixel is the entry of the line buffer at the current X position. It carries a 4-bit sub-palette and a flag that puts it in front of or behind the background. An earlier stage has already reduced the sprites to one candidate per dot by table order. The mixer only resolves that candidate against the background and the backdrop.

From bottom to top the four layers are: the backdrop (index 0), a sprite placed behind the background, the background, and a sprite placed in front. No sprite can fall behind the backdrop. A rear sprite is therefore visible wherever the background pixel is zero. Bit 8 of the index tells the palette stage that a sprite pixel was chosen. Each layer can be switched off by its own enable. A switched-off layer acts as if all its pixels were zero. The result is registered and reaches the output one clock later. It is forced to index 0 whenever the dot lies outside the active display window.

Top module: `pix_layer_mixer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `idx_o` becomes 0 and `valid_o` becomes 0.
- R2: `valid_o` equals `active_i` from the previous clock edge, and `idx_o` is the result for the inputs sampled at that same edge (one cycle of latency).
- R3: If `active_i` was 0, `idx_o` is 0 regardless of any pixel input.
- R4: When the effective background pixel and the effective sprite pixel are both zero, `idx_o` is 0 (the backdrop).
- R5: A winning background pixel gives `idx_o = bg_pal_i*16 + bg_pix_i`, with bit 8 = 0.
- R6: A winning sprite pixel gives `idx_o = 256 + spr_pal_i*16 + spr_pix_i`, with bit 8 = 1. A non-zero sprite over a zero background wins whatever its priority flag says.
- R7: When both pixels are non-zero and `spr_front_i` = 1, the sprite wins.
- R8: When both pixels are non-zero and `spr_front_i` = 0, the background wins.
- R9: With `bg_en_i` = 0, the background pixel is treated as 0.
- R10: With `spr_en_i` = 0, the sprite pixel is treated as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous active-low reset |
| active_i | input | 1 | Dot lies inside the active display window |
| bg_en_i | input | 1 | Background layer enable |
| spr_en_i | input | 1 | Sprite layer enable |
| bg_pix_i | input | 4 | Background pixel value (0 = transparent) |
| bg_pal_i | input | 4 | Background sub-palette |
| spr_pix_i | input | 4 | Sprite pixel value chosen by table order (0 = transparent) |
| spr_pal_i | input | 4 | Sprite sub-palette |
| spr_front_i | input | 1 | 1 = sprite in front of background, 0 = behind it |
| idx_o | output | 9 | Palette index; bit 8 marks a sprite |
| valid_o | output | 1 | Index belongs to an active-display dot |

## Verification
The assertions assume that every input is stable and known at each rising edge once reset has been released. They also assume that the sprite candidate has already been chosen upstream. The mixer cannot tell whether that choice was right. The bench changes inputs only on falling edges. It walks every combination of both pixel values, the priority flag, both enables and the active flag, with sub-palettes derived from the step number. This keeps every dot a legal, fully defined input while still reaching each layer case.

// File: rtl/pixmix_pkg.sv
// Package: shared types for the layered pixel mixer.
// Assumes nothing beyond the fixed four-layer stacking order.
package pixmix_pkg;
    // Which layer supplied the chosen dot.
    typedef enum logic [1:0] {
        SRC_BACKDROP = 2'd0,
        SRC_BG       = 2'd1,
        SRC_SPR      = 2'd2
    } src_e;
endpackage

// File: rtl/pixmix_layer_gate.sv
// Module: pixmix_layer_gate
// Blanks one layer when its enable is low and flags a non-transparent dot.
// Assumes pixel value 0 means transparent.
module pixmix_layer_gate #(
    parameter int unsigned PIX_W = 4
) (
    input  logic             en_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] pix_o,
    output logic             opaque_o
);
    // Force the pixel to transparent when the layer is disabled.
    always_comb begin
        pix_o    = en_i ? pix_i : '0;
        opaque_o = (pix_o != '0);
    end
endmodule

// File: rtl/pixmix_arbiter.sv
// Module: pixmix_arbiter
// Picks backdrop, background or sprite for one dot and forms the index.
// Assumes the sprite is the single candidate already chosen by table order.
module pixmix_arbiter
    import pixmix_pkg::*;
#(
    parameter int unsigned PIX_W = 4,
    parameter int unsigned PAL_W = 4,
    localparam int unsigned IDX_W = 1 + PAL_W + PIX_W
) (
    input  logic             bg_opaque_i,
    input  logic [PIX_W-1:0] bg_pix_i,
    input  logic [PAL_W-1:0] bg_pal_i,
    input  logic             spr_opaque_i,
    input  logic [PIX_W-1:0] spr_pix_i,
    input  logic [PAL_W-1:0] spr_pal_i,
    input  logic             spr_front_i,
    output src_e             src_o,
    output logic [IDX_W-1:0] idx_o
);
    // Resolve layer order: front sprite > background > rear sprite > backdrop.
    always_comb begin
        if (spr_opaque_i && (spr_front_i || !bg_opaque_i)) begin
            src_o = SRC_SPR;
        end else if (bg_opaque_i) begin
            src_o = SRC_BG;
        end else begin
            src_o = SRC_BACKDROP;
        end
    end

    // Build the palette index from the winning layer; bit 8 marks a sprite.
    always_comb begin
        case (src_o)
            SRC_SPR: idx_o = {1'b1, spr_pal_i, spr_pix_i};
            SRC_BG:  idx_o = {1'b0, bg_pal_i, bg_pix_i};
            default: idx_o = '0;
        endcase
    end
endmodule

// File: rtl/pix_layer_mixer.sv
// Module: pix_layer_mixer (top)
// Merges one background dot and one sprite dot into a registered palette
// index, blanked outside active display. Assumes inputs are stable at each
// rising edge and the sprite dot is already resolved by table order.
module pix_layer_mixer
    import pixmix_pkg::*;
#(
    parameter int unsigned PIX_W = 4,
    parameter int unsigned PAL_W = 4,
    localparam int unsigned IDX_W = 1 + PAL_W + PIX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic             bg_en_i,
    input  logic             spr_en_i,
    input  logic [PIX_W-1:0] bg_pix_i,
    input  logic [PAL_W-1:0] bg_pal_i,
    input  logic [PIX_W-1:0] spr_pix_i,
    input  logic [PAL_W-1:0] spr_pal_i,
    input  logic             spr_front_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             valid_o
);
    logic [PIX_W-1:0] bg_pix_g, spr_pix_g;
    logic             bg_opaque, spr_opaque;
    src_e             src_c;
    logic [IDX_W-1:0] idx_c;

    pixmix_layer_gate #(.PIX_W(PIX_W)) u_bg_gate (
        .en_i     (bg_en_i),
        .pix_i    (bg_pix_i),
        .pix_o    (bg_pix_g),
        .opaque_o (bg_opaque)
    );

    pixmix_layer_gate #(.PIX_W(PIX_W)) u_spr_gate (
        .en_i     (spr_en_i),
        .pix_i    (spr_pix_i),
        .pix_o    (spr_pix_g),
        .opaque_o (spr_opaque)
    );

    pixmix_arbiter #(.PIX_W(PIX_W), .PAL_W(PAL_W)) u_arb (
        .bg_opaque_i  (bg_opaque),
        .bg_pix_i     (bg_pix_g),
        .bg_pal_i     (bg_pal_i),
        .spr_opaque_i (spr_opaque),
        .spr_pix_i    (spr_pix_g),
        .spr_pal_i    (spr_pal_i),
        .spr_front_i  (spr_front_i),
        .src_o        (src_c),
        .idx_o        (idx_c)
    );

    // Output register: one cycle latency, blank outside the active window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            idx_o   <= active_i ? idx_c : '0;
            valid_o <= active_i;
        end
    end

    // R2: valid follows the active flag one cycle later.
    p_valid_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> valid_o);
    p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !valid_o);
    // R3: blanked index outside active display.
    p_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (idx_o == '0));
    // R4: both layers transparent gives the backdrop.
    p_backdrop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && (!bg_en_i || bg_pix_i == '0) && (!spr_en_i || spr_pix_i == '0))
        |=> (idx_o == '0));
    // R7: an enabled front sprite always marks bit 8.
    p_front_spr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && spr_en_i && spr_pix_i != '0 && spr_front_i) |=> idx_o[IDX_W-1]);
    // R8: a rear sprite under an opaque background never marks bit 8.
    p_rear_hidden_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && bg_en_i && bg_pix_i != '0 && !spr_front_i) |=> !idx_o[IDX_W-1]);
    // R10: a disabled sprite layer never marks bit 8.
    p_spr_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!spr_en_i) |=> !idx_o[IDX_W-1]);
endmodule

// File: tb/pix_layer_mixer_bench.sv
// Bench: exhaustive sweep of pixel values, priority, enables and active flag.
module pix_layer_mixer_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       active_i, bg_en_i, spr_en_i, spr_front_i;
    logic [3:0] bg_pix_i, bg_pal_i, spr_pix_i, spr_pal_i;
    logic [8:0] idx_o;
    logic       valid_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pix_layer_mixer u_pix_layer_mixer (
        .clk(clk), .rst_n(rst_n), .active_i(active_i),
        .bg_en_i(bg_en_i), .spr_en_i(spr_en_i),
        .bg_pix_i(bg_pix_i), .bg_pal_i(bg_pal_i),
        .spr_pix_i(spr_pix_i), .spr_pal_i(spr_pal_i),
        .spr_front_i(spr_front_i), .idx_o(idx_o), .valid_o(valid_o)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #2000000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int exp_idx;
        string tag;
        int eb, es;
        rst_n = 1'b0; active_i = 1'b1; bg_en_i = 1'b1; spr_en_i = 1'b1;
        spr_front_i = 1'b1; bg_pix_i = 4'h3; bg_pal_i = 4'h2;
        spr_pix_i = 4'h5; spr_pal_i = 4'h7;
        repeat (3) @(negedge clk);
        check("R1 idx", int'(idx_o), 0);
        check("R1 valid", int'(valid_o), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4096; i++) begin
            bg_pix_i    = i[3:0];
            spr_pix_i   = i[7:4];
            spr_front_i = i[8];
            bg_en_i     = i[9];
            spr_en_i    = i[10];
            active_i    = ~i[11];
            bg_pal_i    = 4'((i * 7) >> 2);
            spr_pal_i   = 4'((i * 5) >> 3);
            // Expected index from the layer order.
            eb = bg_en_i ? int'(bg_pix_i) : 0;
            es = spr_en_i ? int'(spr_pix_i) : 0;
            if (!active_i) begin
                exp_idx = 0; tag = "R3";
            end else if (es != 0 && (spr_front_i || eb == 0)) begin
                exp_idx = 256 + int'(spr_pal_i) * 16 + es;
                tag = (eb == 0) ? "R6" : "R7";
            end else if (eb != 0) begin
                exp_idx = int'(bg_pal_i) * 16 + eb;
                tag = (es != 0) ? "R8" : "R5";
            end else begin
                exp_idx = 0; tag = "R4";
            end
            if (active_i && !bg_en_i && bg_pix_i != 0) tag = {tag, "/R9"};
            if (active_i && !spr_en_i && spr_pix_i != 0) tag = {tag, "/R10"};
            @(negedge clk);
            check(tag, int'(idx_o), exp_idx);
            check("R2 valid", int'(valid_o), int'(active_i));
        end
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule